// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the software-visible face of a PS/2 keyboard or mouse port. It sits on a simple word-addressed bus with separate read and write strobes. It keeps a control word, a clock-divider word and the most recently consumed receive byte. Toward the line side it takes received bytes over a valid/ready handshake and hands written bytes to a serializer over a second valid/ready handshake. The serializer, its line clocking and device command handling live elsewhere.

Software polls or takes an interrupt. It reads the status word to see whether a byte is waiting and whether the transmitter is idle. Reading the data word consumes the waiting byte. Writing the data word queues one byte for transmission. A fixed eight-byte identification sequence is returned at the top of the 4 KB window.

Read data is combinational from the address and the current state. State changes, including the receive pop, take effect at the clock edge that ends the read strobe.

Top module: `ps2rf_top`

## Requirements
- R1: The word index is the byte offset shifted right by two, and the two low offset bits are ignored. Index 0 is control, which is read/write and holds 8 bits. Index 3 is the clock divider, which is read/write and holds 8 bits. A write stores the low 8 bits of write data, and a read returns them zero-extended.
- R2: Index 1 is status, and it is read-only. Its bits are as follows, with all other bits reading 0:
  - bit6: transmit empty, which is 1 when no transmit byte is held.
  - bit5: transmit busy, which is 1 when a transmit byte is held.
  - bit4: receive full.
  - bit3: receive busy, which always reads 0.
  - bit2: receive parity.
  - bit1: the line clock input.
  - bit0: the line data input.
- R3: Status bit4 equals `rx_valid`, meaning a byte is waiting on the device side.
- R4: Status bit2 is the XOR of all eight bits of the stored last byte.
- R5: A read of index 2 while `rx_valid` is 1 returns `rx_byte` in bits 7:0 and drives `rx_ready` high in that cycle. From the next cycle, that byte is the stored last byte.
- R6: A read of index 2 while `rx_valid` is 0 returns the stored last byte, leaves it unchanged and keeps `rx_ready` low.
- R7: A write to index 2 while `tx_valid` is 0 raises `tx_valid` on the next cycle, with `tx_byte` set to write data bits 7:0. `tx_valid` and `tx_byte` hold until a cycle with `tx_ready` high. A data write in any cycle where `tx_valid` is 1 is dropped, including the cycle in which `tx_ready` accepts.
- R8: `irq` is high exactly when (`rx_valid` is 1 and control bit4 is 1) or control bit3 is 1. It follows those signals with no added register delay.
- R9: Index 4 is read-only and returns the `rx_valid` state in bit0, 1 in bit1, and 0 elsewhere.
- R10: Reads at offsets 0xFE0 through 0xFFC return one byte per word, in this order: 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of any other offset return 0. Writes to status, the interrupt word, the identification words or undefined offsets change nothing that is visible.
- R12: A synchronous reset clears control, the divider, the stored last byte and `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Device side has a received byte waiting |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Pop of the received byte |
| tx_valid | output | 1 | A transmit byte is held |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the transmit byte |
| line_clk | input | 1 | Sampled line clock level |
| line_dat | input | 1 | Sampled line data level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a data write that lands in the same cycle the serializer accepts the held byte. In that cycle the slot is about to free up, but the write must still be lost. The bench sets up a held byte, then raises `tx_ready` and the write strobe together on one edge. It checks that the slot is empty afterwards, and that a following write loads normally. The receive path is swept over all 256 byte values to pin down the pop, the stored byte and the live parity.

// File: rtl/ps2rf_pkg.sv
package ps2rf_pkg;

  typedef enum logic [2:0] {
    IX_CTRL = 3'd0,
    IX_STAT = 3'd1,
    IX_DATA = 3'd2,
    IX_CDIV = 3'd3,
    IX_IIR  = 3'd4
  } reg_ix_e;

  localparam int ST_TXEMPTY = 6;
  localparam int ST_TXBUSY  = 5;
  localparam int ST_RXFULL  = 4;
  localparam int ST_RXBUSY  = 3;
  localparam int ST_PARITY  = 2;
  localparam int ST_LCLK    = 1;
  localparam int ST_LDAT    = 0;

  localparam int CB_FORCE   = 3;
  localparam int CB_RXEN    = 4;

  function automatic logic byte_parity(input logic [7:0] b);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ b[i];
    return p;
  endfunction

  function automatic logic [7:0] ident_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h50;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic irq_level(input logic pend, input logic rx_en,
                                     input logic force_on);
    return (pend & rx_en) | force_on;
  endfunction

endpackage

// File: rtl/ps2rf_decode.sv
module ps2rf_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              sel_data,
  output logic              sel_cdiv,
  output logic              sel_iir,
  output logic              sel_id,
  output logic [2:0]        id_ix
);
  import ps2rf_pkg::*;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  assign sel_ctrl = (word == WORD_W'(IX_CTRL));
  assign sel_stat = (word == WORD_W'(IX_STAT));
  assign sel_data = (word == WORD_W'(IX_DATA));
  assign sel_cdiv = (word == WORD_W'(IX_CDIV));
  assign sel_iir  = (word == WORD_W'(IX_IIR));
  assign sel_id   = &addr[ADDR_W-1:5];
  assign id_ix    = addr[4:2];
endmodule

// File: rtl/ps2rf_rx.sv
module ps2rf_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       pop_req,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       rx_ready,
  output logic       pop_evt,
  output logic [7:0] last_q,
  output logic [7:0] rd_byte
);
  assign pop_evt  = pop_req & rx_valid;
  assign rx_ready = pop_evt;
  assign rd_byte  = rx_valid ? rx_byte : last_q;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= 8'h00;
    else if (pop_evt) last_q <= rx_byte;
  end
endmodule

// File: rtl/ps2rf_tx.sv
module ps2rf_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic [7:0] wbyte,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       load_evt,
  output logic       drop_evt,
  output logic       accept_evt
);
  assign load_evt   = wr_req & ~tx_valid;
  assign drop_evt   = wr_req & tx_valid;
  assign accept_evt = tx_valid & tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
    end else if (load_evt) begin
      tx_valid <= 1'b1;
      tx_byte  <= wbyte;
    end else if (accept_evt) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2rf_top.sv
module ps2rf_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              line_clk,
  input  logic              line_dat,
  output logic              irq
);
  import ps2rf_pkg::*;

  logic sel_ctrl, sel_stat, sel_data, sel_cdiv, sel_iir, sel_id;
  logic [2:0] id_ix;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  cdiv_q;
  logic [7:0] last_q, rd_byte;
  logic pop_evt, load_evt, drop_evt, accept_evt;
  logic stat_rd;
  logic [7:0] stat_w;

  ps2rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .sel_data(sel_data), .sel_cdiv(sel_cdiv), .sel_iir(sel_iir),
    .sel_id(sel_id), .id_ix(id_ix)
  );

  ps2rf_rx u_rx (
    .clk(clk), .rst(rst), .pop_req(bus_rd & sel_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .pop_evt(pop_evt), .last_q(last_q), .rd_byte(rd_byte)
  );

  ps2rf_tx u_tx (
    .clk(clk), .rst(rst), .wr_req(bus_wr & sel_data),
    .wbyte(bus_wdata[7:0]), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .load_evt(load_evt), .drop_evt(drop_evt), .accept_evt(accept_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cdiv_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (sel_cdiv) cdiv_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    stat_w             = 8'h00;
    stat_w[ST_TXEMPTY] = ~tx_valid;
    stat_w[ST_TXBUSY]  = tx_valid;
    stat_w[ST_RXFULL]  = rx_valid;
    stat_w[ST_RXBUSY]  = 1'b0;
    stat_w[ST_PARITY]  = byte_parity(last_q);
    stat_w[ST_LCLK]    = line_clk;
    stat_w[ST_LDAT]    = line_dat;
  end

  assign stat_rd = bus_rd & sel_stat;

  always_comb begin
    bus_rdata = '0;
    if (sel_id)        bus_rdata = DATA_W'(ident_byte(id_ix));
    else if (sel_ctrl) bus_rdata = DATA_W'(ctrl_q);
    else if (sel_stat) bus_rdata = DATA_W'(stat_w);
    else if (sel_data) bus_rdata = DATA_W'(rd_byte);
    else if (sel_cdiv) bus_rdata = DATA_W'(cdiv_q);
    else if (sel_iir)  bus_rdata = DATA_W'({1'b1, rx_valid});
  end

  assign irq = irq_level(rx_valid, ctrl_q[CB_RXEN], ctrl_q[CB_FORCE]);

endmodule

// File: rtl/ps2rf_checker.sv
module ps2rf_checker #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [7:0]        rx_byte,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [7:0]        last_q,
  input logic              drop_evt,
  input logic              stat_rd,
  input logic [DATA_W-1:0] bus_rdata
);
  a_r3_rxfull_tracks: assert property (@(posedge clk) disable iff (rst)
    stat_rd |-> bus_rdata[4] == rx_valid);

  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> rx_valid);

  a_r5_pop_stores: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> last_q == $past(rx_byte));

  a_r6_idle_keeps_last: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |=> $stable(last_q));

  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  a_r7_drop_keeps_byte: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> $stable(tx_byte));

  a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[3] |-> irq);

  a_r8_quiet_low: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[3] && !rx_valid) |-> !irq);

  a_r12_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && ctrl_q == '0 && last_q == 8'h00));
endmodule

bind ps2rf_top ps2rf_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .tx_ready(tx_ready), .irq(irq), .ctrl_q(ctrl_q), .last_q(last_q),
  .drop_evt(drop_evt), .stat_rd(stat_rd), .bus_rdata(bus_rdata)
);

// File: tb/ps2rf_top_tb.sv
module ps2rf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        line_clk = 1'b0, line_dat = 1'b0;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ps2rf_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .line_clk(line_clk), .line_dat(line_dat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rd_val;
  logic        rd_pop;

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 rd_val = bus_rdata; rd_pop = rx_ready;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R12 reset state
    bus_read(12'h000); chk("R12 ctrl", rd_val, 32'h0);
    bus_read(12'h00C); chk("R12 cdiv", rd_val, 32'h0);
    bus_read(12'h008); chk("R12 last", rd_val, 32'h0);
    chk("R12 tx_valid", {31'b0, tx_valid}, 32'h0);
    bus_read(12'h004); chk("R2 idle status", rd_val, 32'h40);

    // R1 divider and control sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(12'h00C, 32'hA5A5_0000 | v);
      bus_read(12'h00E); chk("R1 cdiv", rd_val, v);
    end
    bus_write(12'h001, 32'h1E7);
    bus_read(12'h000); chk("R1 ctrl", rd_val, 32'hE7);
    bus_write(12'h000, 32'h0);

    // R2 line bits
    line_clk = 1'b1; line_dat = 1'b0;
    bus_read(12'h004); chk("R2 lclk", rd_val, 32'h42);
    line_clk = 1'b0; line_dat = 1'b1;
    bus_read(12'h004); chk("R2 ldat", rd_val, 32'h41);
    line_dat = 1'b0;

    // R3 R4 R5 R6 receive sweep
    for (int b = 0; b < 256; b++) begin
      rx_byte = b[7:0]; rx_valid = 1'b1;
      bus_read(12'h004);
      chk("R3 rxfull", {31'b0, rd_val[4]}, 32'h1);
      bus_read(12'h008);
      chk("R5 pop data", rd_val, b);
      chk("R5 pop strobe", {31'b0, rd_pop}, 32'h1);
      rx_valid = 1'b0; rx_byte = ~b[7:0];
      bus_read(12'h004);
      chk("R4 parity", rd_val, 32'h40 | ((^b[7:0]) ? 32'h4 : 32'h0));
      bus_read(12'h008);
      chk("R6 repeat data", rd_val, b);
      chk("R6 no pop", {31'b0, rd_pop}, 32'h0);
    end

    // R8 interrupt truth table
    for (int c = 0; c < 8; c++) begin
      bus_write(12'h000, {27'b0, c[1], c[0], 3'b0});
      rx_valid = c[2];
      @(negedge clk);
      chk("R8 irq", {31'b0, irq}, {31'b0, (c[2] & c[1]) | c[0]});
    end
    bus_write(12'h000, 32'h0);

    // R9 interrupt identification
    rx_valid = 1'b1;
    bus_read(12'h010); chk("R9 iir pend", rd_val, 32'h3);
    rx_valid = 1'b0;
    bus_read(12'h010); chk("R9 iir idle", rd_val, 32'h2);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      bus_read(12'hFE0 + 12'(i * 4));
      chk("R10 id", rd_val, {24'b0, exp_id(i)});
    end

    // R11 undefined and read-only
    bus_read(12'h014); chk("R11 undef", rd_val, 32'h0);
    bus_read(12'hFDC); chk("R11 below id", rd_val, 32'h0);
    bus_write(12'h00C, 32'h5A);
    bus_write(12'h004, 32'hFF);
    bus_write(12'h010, 32'hFF);
    bus_write(12'h014, 32'hFF);
    bus_write(12'hFE0, 32'hFF);
    bus_read(12'h000); chk("R11 ctrl kept", rd_val, 32'h0);
    bus_read(12'h00C); chk("R11 cdiv kept", rd_val, 32'h5A);
    bus_read(12'h004); chk("R11 status kept", rd_val, 32'h40);
    bus_read(12'hFE0); chk("R11 id kept", rd_val, 32'h50);
    chk("R11 no tx", {31'b0, tx_valid}, 32'h0);

    // R7 transmit holding and drop
    bus_write(12'h008, 32'hABCD_1234);
    chk("R7 load valid", {31'b0, tx_valid}, 32'h1);
    chk("R7 load byte", {24'b0, tx_byte}, 32'h34);
    bus_read(12'h004); chk("R7 busy status", rd_val, 32'h20);
    bus_write(12'h008, 32'h66);
    chk("R7 drop keep", {24'b0, tx_byte}, 32'h34);
    chk("R7 drop valid", {31'b0, tx_valid}, 32'h1);
    @(negedge clk);
    tx_ready = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h55; bus_wr = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0; bus_wr = 1'b0;
    chk("R7 same-cycle drop", {31'b0, tx_valid}, 32'h0);
    bus_write(12'h008, 32'h77);
    chk("R7 reload", {23'b0, tx_valid, tx_byte}, 32'h177);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule